// File: doc/BRIEF.md
# Script Branch Condition Unit

This block decides the outcome of one flow-control instruction for a script-driven bus controller. When the instruction is presented with `exec_i`, the unit tests the enabled conditions in a fixed order against the carry flag, the current bus phase and the first-byte data register. It then chooses the next instruction pointer. Depending on the instruction type it may also write the temp register for a call, read the pointer back from temp for a return, or raise an interrupt that carries a vector.

All results are registered. They appear one cycle after `exec_i`, together with a one-cycle `done_o`. The surrounding sequencer fetches the instruction and its operand. It passes in the pointer already advanced past the instruction, and it consumes `next_ptr_o`, the temp write, and the halt-type signals (`sir_o`, `illegal_o`). Pointer width and the width of the relative offset field are parameters. The instruction field positions are fixed by the instruction format.

Top module: `tc_unit`

## Requirements
- R1: A result appears in the cycle after `exec_i` is high, with `done_o` high for exactly that one cycle. Without `exec_i`, `done_o` stays low.
- R2: If instruction bits 21, 19, 18 and 17 are all zero, the branch is taken whatever the carry, phase and data inputs are.
- R3: Bit 19 is the polarity. The branch is taken only when the final condition equals the polarity. When not taken, `next_ptr_o` equals `ptr_i` and no temp write, interrupt or error is raised.
- R4: With bit 21 set, the carry test (`carry_i` equals the polarity) is applied first. If it fails, the remaining tests have no effect and the branch is not taken.
- R5: With bit 17 set, the phase test compares `phase_i` with instruction bits 26:24. It is applied only after every earlier enabled test has agreed with the polarity.
- R6: With bit 18 set, the data test is applied last. It compares `sfbr_i` with instruction bits 7:0, looking only at the bit positions where bits 15:8 are zero. A bits 15:8 value of 0xFF makes the test always pass.
- R7: With bit 23 clear the target is `operand_i`. With bit 23 set the target is `ptr_i` plus the sign-extended low OFF_W bits of `operand_i`, modulo 2^PTR_W, and the upper operand bits have no effect.
- R8: Bits 29:27 select the type when taken. Type 0 jumps to the target. Type 1 jumps to the target and writes `ptr_i` to temp through `temp_we_o` and `temp_wdata_o`. Type 2 loads `next_ptr_o` from `temp_i`.
- R9: Taken type 3 with bit 20 clear pulses `sir_o`, leaves `next_ptr_o` equal to `ptr_i`, and latches `operand_i` into `vector_o`.
- R10: Taken type 3 with bit 20 set pulses `intfly_o` instead of `sir_o`. It also continues at `ptr_i` and latches `vector_o`.
- R11: Taken types 4 to 7 pulse `illegal_o` with `next_ptr_o` equal to `ptr_i`. At most one of `temp_we_o`, `sir_o`, `intfly_o` and `illegal_o` is high in any cycle.
- R12: After reset every output is zero. `vector_o` changes only on a taken type-3 instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Evaluate the instruction on the inputs this cycle |
| insn_i | input | 32 | Instruction word |
| operand_i | input | PTR_W | Address operand |
| ptr_i | input | PTR_W | Pointer already past the instruction |
| phase_i | input | 3 | Current bus phase |
| carry_i | input | 1 | Carry flag |
| sfbr_i | input | 8 | First-byte data register |
| temp_i | input | PTR_W | Current temp register |
| done_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Condition equalled polarity |
| next_ptr_o | output | PTR_W | Next instruction pointer |
| temp_we_o | output | 1 | Temp write strobe (call) |
| temp_wdata_o | output | PTR_W | Return pointer for temp |
| sir_o | output | 1 | Halting script interrupt |
| intfly_o | output | 1 | Non-halting interrupt flag pulse |
| illegal_o | output | 1 | Illegal instruction type |
| vector_o | output | PTR_W | Last interrupt vector |

## Verification
The bench builds the unit with a 16-bit pointer and a 12-bit offset field. With these sizes, a negative offset from a low pointer wraps through zero, and the operand bits above the offset field can be loaded with junk so that relative mode is seen to ignore them. Every combination of the four condition-field bits is swept against carry, phase match and data match, for all eight types and both addressing modes. This covers each ordering of agreeing and disagreeing tests. Directed cases add the all-ignore and full-compare data masks.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int INSN_W  = 32;
  localparam int PHS_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int B_REL   = 23;
  localparam int B_CARRY = 21;
  localparam int B_FLY   = 20;
  localparam int B_POL   = 19;
  localparam int B_DATA  = 18;
  localparam int B_PHASE = 17;

  typedef enum logic [2:0] {
    OP_JUMP = 3'd0, OP_CALL = 3'd1, OP_RET = 3'd2, OP_INT = 3'd3,
    OP_RSV4 = 3'd4, OP_RSV5 = 3'd5, OP_RSV6 = 3'd6, OP_RSV7 = 3'd7
  } tc_op_e;

  typedef struct packed {
    tc_op_e             op;
    logic [PHS_W-1:0]   phase;
    logic               rel;
    logic               use_carry;
    logic               fly;
    logic               pol;
    logic               use_data;
    logic               use_phase;
    logic [BYTE_W-1:0]  ign_mask;
    logic [BYTE_W-1:0]  dval;
  } tc_fields_t;

  function automatic tc_fields_t tc_decode(input logic [INSN_W-1:0] w);
    tc_fields_t f;
    f.op        = tc_op_e'(w[29:27]);
    f.phase     = w[26:24];
    f.rel       = w[B_REL];
    f.use_carry = w[B_CARRY];
    f.fly       = w[B_FLY];
    f.pol       = w[B_POL];
    f.use_data  = w[B_DATA];
    f.use_phase = w[B_PHASE];
    f.ign_mask  = w[15:8];
    f.dval      = w[7:0];
    return f;
  endfunction
endpackage

// File: rtl/tc_cond_eval.sv
module tc_cond_eval
  import tc_pkg::*;
(
  input  tc_fields_t        fld_i,
  input  logic              carry_i,
  input  logic [PHS_W-1:0]  phase_i,
  input  logic [BYTE_W-1:0] sfbr_i,
  output logic              taken_o
);
  logic [BYTE_W-1:0] cmp_mask;
  logic              cond;

  assign cmp_mask = ~fld_i.ign_mask;

  // terms apply in order only while the condition still matches polarity
  always_comb begin
    cond = fld_i.pol;
    if (fld_i.use_carry && (cond == fld_i.pol))
      cond = carry_i;
    if (fld_i.use_phase && (cond == fld_i.pol))
      cond = (phase_i == fld_i.phase);
    if (fld_i.use_data && (cond == fld_i.pol))
      cond = ((sfbr_i & cmp_mask) == (fld_i.dval & cmp_mask));
  end

  assign taken_o = (cond == fld_i.pol);
endmodule

// File: rtl/tc_target.sv
module tc_target #(
  parameter int PTR_W = 32,
  parameter int OFF_W = 24
) (
  input  logic             rel_i,
  input  logic [PTR_W-1:0] operand_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [PTR_W-1:0] target_o
);
  localparam int EXT_W = PTR_W - OFF_W;

  logic [PTR_W-1:0] offset;

  generate
    if (EXT_W > 0) begin : g_sext
      assign offset = {{EXT_W{operand_i[OFF_W-1]}}, operand_i[OFF_W-1:0]};
    end else begin : g_full
      assign offset = operand_i;
    end
  endgenerate

  assign target_o = rel_i ? (ptr_i + offset) : operand_i;
endmodule

// File: rtl/tc_action.sv
module tc_action
  import tc_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  tc_fields_t       fld_i,
  input  logic             taken_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [PTR_W-1:0] target_i,
  input  logic [PTR_W-1:0] temp_i,
  output logic [PTR_W-1:0] next_ptr_o,
  output logic             temp_we_o,
  output logic             sir_o,
  output logic             fly_o,
  output logic             illegal_o,
  output logic             vec_we_o
);
  always_comb begin
    next_ptr_o = ptr_i;
    temp_we_o  = 1'b0;
    sir_o      = 1'b0;
    fly_o      = 1'b0;
    illegal_o  = 1'b0;
    vec_we_o   = 1'b0;
    if (taken_i) begin
      unique case (fld_i.op)
        OP_JUMP: next_ptr_o = target_i;
        OP_CALL: begin
          next_ptr_o = target_i;
          temp_we_o  = 1'b1;
        end
        OP_RET:  next_ptr_o = temp_i;
        OP_INT: begin
          vec_we_o = 1'b1;
          if (fld_i.fly) fly_o = 1'b1;
          else           sir_o = 1'b1;
        end
        default: illegal_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tc_unit.sv
module tc_unit
  import tc_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int OFF_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [PTR_W-1:0]  operand_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [PHS_W-1:0]  phase_i,
  input  logic              carry_i,
  input  logic [BYTE_W-1:0] sfbr_i,
  input  logic [PTR_W-1:0]  temp_i,
  output logic              done_o,
  output logic              taken_o,
  output logic [PTR_W-1:0]  next_ptr_o,
  output logic              temp_we_o,
  output logic [PTR_W-1:0]  temp_wdata_o,
  output logic              sir_o,
  output logic              intfly_o,
  output logic              illegal_o,
  output logic [PTR_W-1:0]  vector_o
);
  tc_fields_t       fld;
  logic             taken_c;
  logic [PTR_W-1:0] target_c;
  logic [PTR_W-1:0] next_c;
  logic             twe_c, sir_c, fly_c, ill_c, vwe_c;

  assign fld = tc_decode(insn_i);

  tc_cond_eval u_cond (
    .fld_i   (fld),
    .carry_i (carry_i),
    .phase_i (phase_i),
    .sfbr_i  (sfbr_i),
    .taken_o (taken_c)
  );

  tc_target #(.PTR_W(PTR_W), .OFF_W(OFF_W)) u_tgt (
    .rel_i     (fld.rel),
    .operand_i (operand_i),
    .ptr_i     (ptr_i),
    .target_o  (target_c)
  );

  tc_action #(.PTR_W(PTR_W)) u_act (
    .fld_i      (fld),
    .taken_i    (taken_c),
    .ptr_i      (ptr_i),
    .target_i   (target_c),
    .temp_i     (temp_i),
    .next_ptr_o (next_c),
    .temp_we_o  (twe_c),
    .sir_o      (sir_c),
    .fly_o      (fly_c),
    .illegal_o  (ill_c),
    .vec_we_o   (vwe_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      taken_o      <= 1'b0;
      next_ptr_o   <= '0;
      temp_we_o    <= 1'b0;
      temp_wdata_o <= '0;
      sir_o        <= 1'b0;
      intfly_o     <= 1'b0;
      illegal_o    <= 1'b0;
      vector_o     <= '0;
    end else begin
      done_o    <= exec_i;
      taken_o   <= exec_i & taken_c;
      temp_we_o <= exec_i & twe_c;
      sir_o     <= exec_i & sir_c;
      intfly_o  <= exec_i & fly_c;
      illegal_o <= exec_i & ill_c;
      if (exec_i) begin
        next_ptr_o   <= next_c;
        temp_wdata_o <= ptr_i;
        if (vwe_c) vector_o <= operand_i;
      end
    end
  end
endmodule

// File: rtl/tc_unit_chk.sv
module tc_unit_chk #(
  parameter int PTR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic [31:0]       insn_i,
  input logic              carry_i,
  input logic [PTR_W-1:0]  temp_i,
  input logic              done_o,
  input logic              taken_o,
  input logic [PTR_W-1:0]  next_ptr_o,
  input logic              temp_we_o,
  input logic              sir_o,
  input logic              intfly_o,
  input logic              illegal_o,
  input logic [PTR_W-1:0]  vector_o
);
  logic uncond;
  assign uncond = (insn_i[21] | insn_i[19] | insn_i[18] | insn_i[17]) == 1'b0;

  p_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> done_o);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> !done_o);
  p_uncond_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && uncond |=> taken_o);
  p_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> !temp_we_o && !sir_o && !intfly_o && !illegal_o);
  p_carry_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && insn_i[21] && (carry_i != insn_i[19]) |=> !taken_o);
  p_ret_temp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && uncond && insn_i[29:27] == 3'd2 |=> next_ptr_o == $past(temp_i));
  p_bad_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && uncond && insn_i[29] |=> illegal_o);
  p_one_event_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({temp_we_o, sir_o, intfly_o, illegal_o}));
  p_vec_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_i && insn_i[29:27] == 3'd3) |=> $stable(vector_o));
endmodule

bind tc_unit tc_unit_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .insn_i(insn_i),
  .carry_i(carry_i), .temp_i(temp_i), .done_o(done_o), .taken_o(taken_o),
  .next_ptr_o(next_ptr_o), .temp_we_o(temp_we_o), .sir_o(sir_o),
  .intfly_o(intfly_o), .illegal_o(illegal_o), .vector_o(vector_o)
);

// File: tb/tc_unit_test.sv
module tc_unit_test;
  localparam int PW = 16;
  localparam int OW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          exec = 1'b0;
  logic [31:0]   insn = '0;
  logic [PW-1:0] operand = '0, ptr = '0, temp = '0;
  logic [2:0]    phase = '0;
  logic          carry = 1'b0;
  logic [7:0]    sfbr = '0;
  logic          done, taken, twe, sir, fly, ill;
  logic [PW-1:0] nptr, twd, vec;

  int checks = 0;
  int fails = 0;
  logic [PW-1:0] exp_vec = '0;

  always #10 clk = ~clk;

  tc_unit #(.PTR_W(PW), .OFF_W(OW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .insn_i(insn),
    .operand_i(operand), .ptr_i(ptr), .phase_i(phase), .carry_i(carry),
    .sfbr_i(sfbr), .temp_i(temp), .done_o(done), .taken_o(taken),
    .next_ptr_o(nptr), .temp_we_o(twe), .temp_wdata_o(twd), .sir_o(sir),
    .intfly_o(fly), .illegal_o(ill), .vector_o(vec)
  );

  task automatic check(input string tag, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // taken when every enabled test yields the polarity
  function automatic bit model_take(input logic [31:0] w, input bit cy,
                                    input logic [2:0] ph, input logic [7:0] sf);
    bit pol = w[19];
    bit ok = 1'b1;
    if (w[21] && (cy != pol)) ok = 1'b0;
    if (w[17] && ((ph == w[26:24]) != pol)) ok = 1'b0;
    if (w[18] && ((((sf ^ w[7:0]) & ~w[15:8]) == 8'h00) != pol)) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [PW-1:0] model_target(input logic [31:0] w,
                                                 input logic [PW-1:0] op,
                                                 input logic [PW-1:0] p);
    int off;
    if (!w[23]) return op;
    off = int'(op) % (1 << OW);
    if (off >= (1 << (OW - 1))) off -= (1 << OW);
    return PW'((int'(p) + off + (1 << PW)) % (1 << PW));
  endfunction

  task automatic apply(input logic [31:0] w, input logic [PW-1:0] op,
                       input logic [PW-1:0] p, input logic [2:0] ph,
                       input bit cy, input logic [7:0] sf, input logic [PW-1:0] tp);
    @(negedge clk);
    insn = w; operand = op; ptr = p; phase = ph; carry = cy; sfbr = sf; temp = tp;
    exec = 1'b1;
    @(negedge clk);
    exec = 1'b0;
  endtask

  // full expected-result comparison for one instruction
  task automatic run_one(input string tag, input logic [31:0] w,
                         input logic [PW-1:0] op, input logic [PW-1:0] p,
                         input logic [2:0] ph, input bit cy,
                         input logic [7:0] sf, input logic [PW-1:0] tp);
    bit tk;
    logic [2:0] ty;
    logic [PW-1:0] e_next;
    bit e_we, e_sir, e_fly, e_ill;
    tk = model_take(w, cy, ph, sf);
    ty = w[29:27];
    e_next = p; e_we = 0; e_sir = 0; e_fly = 0; e_ill = 0;
    if (tk) begin
      case (ty)
        3'd0: e_next = model_target(w, op, p);
        3'd1: begin e_next = model_target(w, op, p); e_we = 1; end
        3'd2: e_next = tp;
        3'd3: begin exp_vec = op; if (w[20]) e_fly = 1; else e_sir = 1; end
        default: e_ill = 1;
      endcase
    end
    apply(w, op, p, ph, cy, sf, tp);
    check(tag, "result",
          {done, taken, nptr, twe, (twe ? twd : {PW{1'b0}}), sir, fly, ill, vec},
          {1'b1, tk, e_next, e_we, (e_we ? p : {PW{1'b0}}), e_sir, e_fly, e_ill, exp_vec});
  endtask

  function automatic logic [31:0] mk(input logic [2:0] ty, input logic [2:0] phf,
                                     input bit rel, input bit uc, input bit fl,
                                     input bit pol, input bit ud, input bit up,
                                     input logic [7:0] ign, input logic [7:0] dv);
    return {2'b10, ty, phf, rel, 1'b0, uc, fl, pol, ud, up, 1'b0, ign, dv};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state, R1 idle
    check("R12", "reset outputs",
          {70'd0, done, taken, twe, sir, fly, ill, 4'd0},
          80'd0);
    check("R12", "reset ptr/vec", {48'd0, nptr, vec}, 80'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "no done without exec", {79'd0, done}, 80'd0);

    // R1 latency and single-cycle pulse
    apply(mk(3'd0, 3'd0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00), 16'h0200, 16'h0010, 3'd0, 0, 8'h00, 16'h0);
    check("R1", "done after exec", {78'd0, done, nptr == 16'h0200}, {78'd0, 2'b11});
    @(negedge clk);
    check("R1", "done one cycle", {79'd0, done}, 80'd0);

    // R2 empty condition taken even with polarity 0
    run_one("R2", mk(3'd0, 3'd1, 0, 0, 0, 0, 0, 0, 8'h00, 8'hFF), 16'h1234, 16'h0040, 3'd6, 0, 8'h00, 16'h0);
    // R4 carry disagrees, matching phase cannot rescue
    run_one("R4", mk(3'd0, 3'd2, 0, 1, 0, 1, 0, 1, 8'h00, 8'h00), 16'h0300, 16'h0050, 3'd2, 0, 8'h00, 16'h0);
    // R5 jump-if-false with mismatching phase
    run_one("R5", mk(3'd0, 3'd2, 0, 0, 0, 0, 0, 1, 8'h00, 8'h00), 16'h0310, 16'h0060, 3'd5, 0, 8'h00, 16'h0);
    // R6 all-ignore mask passes, full mask mismatch fails
    run_one("R6", mk(3'd0, 3'd0, 0, 0, 0, 1, 1, 0, 8'hFF, 8'h00), 16'h0320, 16'h0070, 3'd0, 0, 8'hC3, 16'h0);
    run_one("R6", mk(3'd0, 3'd0, 0, 0, 0, 1, 1, 0, 8'h00, 8'h5B), 16'h0330, 16'h0080, 3'd0, 0, 8'h5A, 16'h0);
    // R7 relative wrap below zero, upper operand bits ignored
    run_one("R7", mk(3'd0, 3'd0, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00), 16'hBFF0, 16'h0004, 3'd0, 0, 8'h00, 16'h0);
    check("R7", "wrap target", {64'd0, nptr}, {64'd0, 16'hFFF4});
    // R9 then R12 vector holds across a jump
    run_one("R9", mk(3'd3, 3'd0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00), 16'h7E11, 16'h0090, 3'd0, 0, 8'h00, 16'h0);
    run_one("R12", mk(3'd0, 3'd0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00), 16'h0400, 16'h00A0, 3'd0, 0, 8'h00, 16'h0);
    check("R12", "vector kept", {64'd0, vec}, {64'd0, 16'h7E11});

    // sweep: all types, addressing modes, condition fields and input agreements
    for (int ty = 0; ty < 8; ty++)
      for (int rl = 0; rl < 2; rl++)
        for (int cf = 0; cf < 16; cf++)
          for (int cy = 0; cy < 2; cy++)
            for (int pm = 0; pm < 2; pm++)
              for (int dm = 0; dm < 2; dm++) begin
                logic [2:0] phf;
                logic [31:0] w;
                string tag;
                bit tk;
                phf = 3'(ty) ^ 3'd5;
                w = mk(3'(ty), phf, rl[0], cf[3], rl[0] ^ cf[0], cf[2], cf[1], cf[0],
                       8'hF0, dm[0] ? 8'h3A : 8'h3B);
                tk = model_take(w, cy[0], pm[0] ? phf : phf ^ 3'd2, 8'h5A);
                if (!tk) tag = "R3";
                else if (ty < 3) tag = "R8";
                else if (ty == 3) tag = w[20] ? "R10" : "R9";
                else tag = "R11";
                run_one(tag, w, cy[0] ? 16'hAFF0 : 16'hA7F0, 16'h0120 + 16'(cf * 8),
                        pm[0] ? phf : phf ^ 3'd2, cy[0], 8'h5A, 16'h4C44);
              end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule